// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a parameterized set of level-high interrupt request lines (32 by default, up to 240) and decides which of them, if any, a processor should service next. Each line carries an enable bit, a pending bit, an active bit and a programmable priority. The controller presents the best eligible request as a valid flag plus an interrupt number. The processor answers with an acknowledge, which starts service, and later with an end-of-service, which finishes it.

Software programs the controller through a word-addressed register port. The address is `{region[2:0], word[IDX_W-1:0]}`. The regions are: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active status, 5 priority, 6 software trigger, 7 global mask. Writes take effect at the next clock edge, and reads are combinational. An internal nesting stack records which line was preempted and the level it ran at, so end-of-service can return to the interrupted level. Nested preemption is limited to a configurable depth.

Top module: `prio_irq_ctrl`

## Requirements
- R1: In regions 0 and 1, bit b of word w maps to line 32*w+b. Writing 1 to a bit in region 0 enables that line, and writing 1 in region 1 disables it. Writing 0 changes nothing. Reading either region returns the enable bits, and bits for lines at or above NUM_IRQ read 0.
- R2: Regions 2 and 3 set and clear pending bits with the same write-one semantics and the same bit mapping, and either region reads the pending bits. A line whose `irq_in` is high becomes pending on every clock.
- R3: In region 5, word w holds lines 4*w to 4*w+3, with line 4*w+k in byte k. Only the upper PRIO_BITS bits of each byte are stored, and the remaining bits read 0.
- R4: Among the lines that are enabled, pending and not active, the one with the numerically smallest priority is presented on `req_id`. On equal priority, the lower line number wins.
- R5: While the global mask (bit 0 of region 7) is 1, `req_valid` is 0.
- R6: Writing a line number to bits [7:0] of region 6 makes that line pending. A number at or above NUM_IRQ changes nothing.
- R7: An acknowledge while `req_valid` is high clears the presented line's pending bit and sets its active bit. `cur_level` then becomes that line's priority, and region 4 reads the active bits.
- R8: A candidate is presented only if its priority is strictly below `cur_level`. `cur_level` is 2^PRIO_BITS when nothing is active.
- R9: End-of-service clears the active bit of the most recently acknowledged line that is still active, and restores the level that was running before it.
- R10: If a line's `irq_in` stays high while the line is active, the line becomes active and pending at the same time.
- R11: When NEST_DEPTH lines are active, no request is presented.
- R12: A line whose enable bit is 0 is never presented.
- R13: When acknowledge and end-of-service arrive in the same cycle, only the end-of-service takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Level-high request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address {region, word} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| req_valid | output | 1 | A request is offered to the processor |
| req_id | output | ID_W | Number of the offered line |
| ack | input | 1 | Processor takes the offered request |
| eoi | input | 1 | Processor finishes the current handler |
| cur_level | output | PRIO_BITS+1 | Running priority level |

## Verification
The bench builds the block with NUM_IRQ = 40, PRIO_BITS = 4 and NEST_DEPTH = 3. With 40 lines the second bit-mapped word is only partly populated, which exercises the reads of unused bits and a software trigger number that lies past the last line. A depth of three lets a short chain of nested acknowledges fill the stack and then show that a request is held back until an end-of-service frees a slot. Random priority, enable and pending patterns across all 40 lines exercise lowest-number selection and the lower-index tie rule.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned PIC_DATA_W = 32;
    localparam int unsigned PIC_LINES_PER_WORD = 32;
    localparam int unsigned PIC_LANES = 4;

    typedef enum logic [2:0] {
        RG_EN_SET  = 3'd0,
        RG_EN_CLR  = 3'd1,
        RG_PD_SET  = 3'd2,
        RG_PD_CLR  = 3'd3,
        RG_ACTIVE  = 3'd4,
        RG_PRIO    = 3'd5,
        RG_SWTRIG  = 3'd6,
        RG_MASK    = 3'd7
    } pic_region_e;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 4,
    parameter int ID_W      = 5
) (
    input  logic [NUM_IRQ-1:0]           cand,
    input  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat,
    output logic                         found,
    output logic [ID_W-1:0]              win_id,
    output logic [PRIO_BITS-1:0]         win_prio
);
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!found || prio_flat[i*PRIO_BITS +: PRIO_BITS] < win_prio)) begin
                found    = 1'b1;
                win_prio = prio_flat[i*PRIO_BITS +: PRIO_BITS];
                win_id   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 5,
    parameter int LVL_W = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [ID_W-1:0]  push_id,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [ID_W-1:0]  top_id,
    output logic [LVL_W-1:0] top_lvl,
    output logic [CNT_W-1:0] depth,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0]  ids;
        logic [DEPTH-1:0][LVL_W-1:0] lvls;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    assign depth = stk_q.cnt;
    assign full  = (stk_q.cnt == CNT_W'(DEPTH));
    assign empty = (stk_q.cnt == '0);

    always_comb begin
        top_id  = '0;
        top_lvl = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (stk_q.cnt == CNT_W'(k + 1)) begin
                top_id  = stk_q.ids[k];
                top_lvl = stk_q.lvls[k];
            end
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (pop && !empty) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end else if (push && !full) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (stk_q.cnt == CNT_W'(k)) begin
                    stk_d.ids[k]  = push_id;
                    stk_d.lvls[k] = push_lvl;
                end
            end
            stk_d.cnt = stk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_BITS  = 4,
    parameter int NEST_DEPTH = 4,
    localparam int ID_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int PRIO_WORDS = (NUM_IRQ + 3) / 4,
    localparam int IDX_W      = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1,
    localparam int ADDR_W     = 3 + IDX_W,
    localparam int LVL_W      = PRIO_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               req_valid,
    output logic [ID_W-1:0]    req_id,
    input  logic               ack,
    input  logic               eoi,
    output logic [LVL_W-1:0]   cur_level
);
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_BITS);
    localparam int CNT_W = $clog2(NEST_DEPTH + 1);
    localparam int LSB_OFS = 8 - PRIO_BITS;

    typedef struct packed {
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_IRQ-1:0]                pend;
        logic [NUM_IRQ-1:0]                act;
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
        logic [LVL_W-1:0]                  lvl;
        logic                              gmask;
    } ctl_t;

    ctl_t st_d, st_q;

    pic_region_e       region;
    logic [IDX_W-1:0]  widx;
    logic              arb_found;
    logic [ID_W-1:0]   arb_id;
    logic [PRIO_BITS-1:0] arb_prio;
    logic              do_ack, do_eoi;
    logic [ID_W-1:0]   top_id;
    logic [LVL_W-1:0]  top_lvl;
    logic [CNT_W-1:0]  stk_depth;
    logic              stk_full, stk_empty;
    logic              gmask_q;
    logic [NUM_IRQ-1:0] act_q;

    assign region  = pic_region_e'(reg_addr[ADDR_W-1 -: 3]);
    assign widx    = reg_addr[IDX_W-1:0];
    assign gmask_q = st_q.gmask;
    assign act_q   = st_q.act;

    pic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
        .cand      (st_q.en & st_q.pend & ~st_q.act),
        .prio_flat (st_q.prio),
        .found     (arb_found),
        .win_id    (arb_id),
        .win_prio  (arb_prio)
    );

    pic_nest_stack #(.DEPTH(NEST_DEPTH), .ID_W(ID_W), .LVL_W(LVL_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_ack),
        .pop      (do_eoi),
        .push_id  (arb_id),
        .push_lvl (st_q.lvl),
        .top_id   (top_id),
        .top_lvl  (top_lvl),
        .depth    (stk_depth),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    assign req_valid = arb_found && !st_q.gmask && !stk_full
                       && ({1'b0, arb_prio} < st_q.lvl);
    assign req_id    = arb_id;
    assign cur_level = st_q.lvl;
    assign do_eoi    = eoi && !stk_empty;
    assign do_ack    = ack && req_valid && !eoi;

    // register read path
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (widx == IDX_W'(i / PIC_LINES_PER_WORD)) begin
                case (region)
                    RG_EN_SET, RG_EN_CLR: reg_rdata[i % PIC_LINES_PER_WORD] = st_q.en[i];
                    RG_PD_SET, RG_PD_CLR: reg_rdata[i % PIC_LINES_PER_WORD] = st_q.pend[i];
                    RG_ACTIVE:            reg_rdata[i % PIC_LINES_PER_WORD] = st_q.act[i];
                    default: ;
                endcase
            end
            if (region == RG_PRIO && widx == IDX_W'(i / PIC_LANES))
                reg_rdata[(i % PIC_LANES)*8 + LSB_OFS +: PRIO_BITS] = st_q.prio[i];
        end
        if (region == RG_MASK) reg_rdata[0] = st_q.gmask;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            logic bit_hit;
            bit_hit = reg_we && (widx == IDX_W'(i / PIC_LINES_PER_WORD))
                      && reg_wdata[i % PIC_LINES_PER_WORD];
            if (bit_hit && region == RG_EN_SET) st_d.en[i] = 1'b1;
            if (bit_hit && region == RG_EN_CLR) st_d.en[i] = 1'b0;
            if (irq_in[i]) st_d.pend[i] = 1'b1;
            if (bit_hit && region == RG_PD_SET) st_d.pend[i] = 1'b1;
            if (reg_we && region == RG_SWTRIG && reg_wdata[7:0] == 8'(i))
                st_d.pend[i] = 1'b1;
            if (bit_hit && region == RG_PD_CLR) st_d.pend[i] = 1'b0;
            if (reg_we && region == RG_PRIO && widx == IDX_W'(i / PIC_LANES))
                st_d.prio[i] = reg_wdata[(i % PIC_LANES)*8 + LSB_OFS +: PRIO_BITS];
        end
        if (reg_we && region == RG_MASK) st_d.gmask = reg_wdata[0];
        if (do_eoi) begin
            st_d.act[top_id] = 1'b0;
            st_d.lvl         = top_lvl;
        end
        if (do_ack) begin
            st_d.pend[arb_id] = 1'b0;
            st_d.act[arb_id]  = 1'b1;
            st_d.lvl          = {1'b0, arb_prio};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lvl <= IDLE_LVL;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_BITS  = 4,
    parameter int NEST_DEPTH = 4,
    parameter int ID_W       = 5,
    parameter int CNT_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [ID_W-1:0]      req_id,
    input logic                 ack,
    input logic                 eoi,
    input logic [PRIO_BITS:0]   cur_level,
    input logic                 gmask,
    input logic [NUM_IRQ-1:0]   act,
    input logic [CNT_W-1:0]     depth
);
    localparam logic [PRIO_BITS:0] IDLE = (PRIO_BITS+1)'(1 << PRIO_BITS);

    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && !eoi) |=> act[$past(req_id)]); // R7
    AST_ACK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && !eoi) |=> (cur_level < $past(cur_level))); // R8
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> !req_valid); // R5
    AST_EOI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && depth != '0) |=> (cur_level > $past(cur_level))); // R9
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0) |-> (cur_level == IDLE)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(NEST_DEPTH)); // R11
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == CNT_W'(NEST_DEPTH)) |-> !req_valid); // R11
    AST_EOI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && eoi && depth != '0) |=> (depth == $past(depth) - 1'b1)); // R13
endmodule

bind prio_irq_ctrl pic_checker #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .NEST_DEPTH(NEST_DEPTH),
    .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_id    (req_id),
    .ack       (ack),
    .eoi       (eoi),
    .cur_level (cur_level),
    .gmask     (gmask_q),
    .act       (act_q),
    .depth     (stk_depth)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 40;
    localparam int PB  = 4;
    localparam int ND  = 3;
    localparam int IDW = 6;
    localparam int AW  = 7;
    localparam int LW  = 5;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] irq_in = '0;
    logic reg_we = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic req_valid, ack = 0, eoi = 0;
    logic [IDW-1:0] req_id;
    logic [LW-1:0] cur_level;
    int checks = 0, fails = 0, cycles = 0;
    int bprio [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_BITS(PB), .NEST_DEPTH(ND)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_id(req_id), .ack(ack), .eoi(eoi),
        .cur_level(cur_level)
    );

    function automatic logic [AW-1:0] ra(input int region, input int word);
        return AW'(region * 16 + word);
    endfunction

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expect_v);
        checks++;
        if (actual !== expect_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, actual, expect_v);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic a_in, input logic e_in);
        @(negedge clk);
        ack = a_in; eoi = e_in;
        @(negedge clk);
        ack = 0; eoi = 0;
    endtask

    task automatic chk_req(input string req, input logic v, input int id);
        chk(req, {31'b0, req_valid}, {31'b0, v});
        if (v) chk(req, 32'(req_id), 32'(id));
    endtask

    // expected winner among enabled pending lines, idle level
    function automatic int best_line(input logic [N-1:0] cand);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (cand[i] && (b < 0 || bprio[i] < bprio[b])) b = i;
        return b;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        chk("R8 reset valid", {31'b0, req_valid}, 0);
        chk("R8 reset level", 32'(cur_level), 16);
        rd(ra(0,0), d); chk("R1 reset enable", d, 0);
        rd(ra(5,0), d); chk("R3 reset prio", d, 0);

        // R1 enable set/clear
        wr(ra(0,0), 32'h0000_00F0); rd(ra(0,0), d); chk("R1 set", d, 32'hF0);
        wr(ra(0,0), 32'h0); rd(ra(1,0), d); chk("R1 zero write", d, 32'hF0);
        wr(ra(1,0), 32'h30); rd(ra(0,0), d); chk("R1 clear", d, 32'hC0);
        wr(ra(0,1), 32'hFFFF_FFFF); rd(ra(0,1), d); chk("R1 unused bits", d, 32'hFF);
        wr(ra(1,0), '1); wr(ra(1,1), '1);

        // R3 priority layout
        wr(ra(5,1), 32'hFFFF_FFFF); rd(ra(5,1), d); chk("R3 low bits zero", d, 32'hF0F0_F0F0);
        wr(ra(5,1), 32'h1234_5678); rd(ra(5,1), d); chk("R3 lanes", d, 32'h1030_5070);

        // R6 software trigger
        wr(ra(6,0), 32'd5); rd(ra(2,0), d); chk("R6 trigger", d, 32'h20);
        wr(ra(6,0), 32'd45); rd(ra(2,0), d); chk("R6 out of range w0", d, 32'h20);
        rd(ra(2,1), d); chk("R6 out of range w1", d, 0);
        wr(ra(6,0), 32'd33); rd(ra(3,1), d); chk("R6 upper word", d, 32'h2);
        wr(ra(3,0), '1); wr(ra(3,1), '1);

        // R2 pending set/clear
        wr(ra(2,0), 32'h81); rd(ra(2,0), d); chk("R2 set", d, 32'h81);
        wr(ra(2,0), 32'h0); rd(ra(2,0), d); chk("R2 zero write", d, 32'h81);
        wr(ra(3,0), 32'h01); rd(ra(2,0), d); chk("R2 clear", d, 32'h80);
        chk_req("R12 pending but disabled", 0, 0);
        wr(ra(3,0), '1);

        // R4 / R12 random arbitration
        for (int it = 0; it < 24; it++) begin
            logic [31:0] e0, e1, p0, p1;
            logic [N-1:0] cand;
            int b;
            for (int w = 0; w < 10; w++) begin
                logic [31:0] pv;
                pv = $urandom & 32'h3333_3333;   // few levels, frequent ties
                if (it % 3 == 0) pv = $urandom;
                wr(ra(5,w), pv);
                for (int l = 0; l < 4; l++) bprio[w*4+l] = int'(pv[l*8+4 +: 4]);
            end
            e0 = $urandom; e1 = $urandom & 32'hFF;
            p0 = $urandom; p1 = $urandom & 32'hFF;
            if (it == 5) e0 = 0;
            wr(ra(0,0), e0); wr(ra(0,1), e1);
            wr(ra(2,0), p0); wr(ra(2,1), p1);
            cand = {e1[7:0] & p1[7:0], e0 & p0};
            b = best_line(cand);
            chk_req("R4 R12 arbitration", b >= 0, (b < 0) ? 0 : b);
            wr(ra(1,0), '1); wr(ra(1,1), '1); wr(ra(3,0), '1); wr(ra(3,1), '1);
        end

        // directed nesting scenario
        wr(ra(5,0), 32'h5000_0000);         // line 3 -> 5
        wr(ra(5,1), 32'h6000_0000);         // line 7 -> 6
        wr(ra(5,2), 32'h4050_0000);         // line 10 -> 5, line 11 -> 4
        wr(ra(5,5), 32'h0000_1020);         // line 20 -> 2, line 21 -> 1
        wr(ra(0,0), 32'h0030_0C08);
        wr(ra(2,0), 32'h8);
        chk_req("R5 baseline", 1, 3);
        wr(ra(7,0), 32'h1); chk_req("R5 masked", 0, 0);
        wr(ra(7,0), 32'h0); chk_req("R5 unmasked", 1, 3);

        pulse(1, 0);
        rd(ra(4,0), d); chk("R7 active", d, 32'h8);
        rd(ra(2,0), d); chk("R7 pending cleared", d, 0);
        chk("R7 level", 32'(cur_level), 5);

        wr(ra(2,0), 32'h400); chk_req("R8 equal priority held", 0, 0);
        wr(ra(2,0), 32'h800); chk_req("R8 lower number preempts", 1, 11);
        pulse(1, 0);
        chk("R8 level", 32'(cur_level), 4);
        wr(ra(2,0), 32'h10_0000); chk_req("R8 second preempt", 1, 20);
        pulse(1, 0);
        chk("R11 level", 32'(cur_level), 2);
        wr(ra(2,0), 32'h20_0000); chk_req("R11 stack full", 0, 0);

        pulse(0, 1);
        chk("R9 restored level", 32'(cur_level), 4);
        rd(ra(4,0), d); chk("R9 active cleared", d, 32'h808);
        chk_req("R11 slot freed", 1, 21);

        pulse(1, 1);
        chk("R13 level", 32'(cur_level), 5);
        rd(ra(4,0), d); chk("R13 active", d, 32'h8);
        rd(ra(2,0), d); chk("R13 pending kept", d, 32'h20_0400);

        pulse(1, 0); pulse(0, 1); pulse(0, 1);
        chk("R9 idle level", 32'(cur_level), 16);
        chk_req("R9 held request now served", 1, 10);
        pulse(1, 0); pulse(0, 1);
        rd(ra(4,0), d); chk("R9 all done", d, 0);
        wr(ra(1,0), '1); wr(ra(3,0), '1);

        // R10 active and pending
        wr(ra(0,0), 32'h80);
        @(negedge clk); irq_in[7] = 1'b1;
        @(negedge clk); chk_req("R10 level request", 1, 7);
        pulse(1, 0);
        @(negedge clk);
        rd(ra(4,0), d); chk("R10 active", d, 32'h80);
        rd(ra(2,0), d); chk("R10 pending again", d, 32'h80);
        irq_in[7] = 1'b0;
        pulse(0, 1);
        rd(ra(4,0), d); chk("R10 active after eoi", d, 0);
        chk_req("R10 re-presented", 1, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule